// File: doc/BRIEF.md
# Root Port Resume Sequencer

This block runs the wake-up sequence of one host-side USB root port that sits in suspend. A single resume request bit starts the sequence. Software can set it through a small write port, or the port sets it on its own when it sees a remote device pull the line from J to K. Once the bit is set, the block drives full-speed K onto the bus for a fixed number of clock ticks. It then drives a short end-of-resume SE0 period and clears the bit by itself. Software never has to time the interval or clear the bit.

Two single-cycle pulses tell the rest of the host where the sequence stands. The first marks the last cycle of K drive, so that the run bit can be raised and start-of-frame traffic can follow within the 3 ms that a high-speed device allows. The second marks the last cycle of the SE0 period, just before the port returns to idle. A remote wake also raises a sticky port-change flag, which software clears by writing one. Losing port power forces the bit and every drive output low at once and cancels the sequence.

Top module: `port_wake_ctrl`

## Requirements
- R1: After reset, resume_req, k_drive, eop_drive, k_final, idle_enter and chg_flag are all 0.
- R2: A write cycle (wr_en=1) with wr_resume=1, while port_pwr=1, port_susp=1 and no sequence is active, sets resume_req on the next clock edge, and k_drive rises with it.
- R3: k_drive stays 1 for exactly RESUME_TICKS cycles from the start edge. k_final is 1 only during the last of those cycles.
- R4: After the K period, eop_drive is 1 for exactly EOP_TICKS cycles, and idle_enter is 1 only in the last of them. On the following edge resume_req clears by itself. k_drive and eop_drive are never 1 together.
- R5: A write with wr_resume=0 during an active sequence leaves the sequence and its length unchanged.
- R6: A write with wr_resume=1 has no effect while port_susp=0 or port_pwr=0.
- R7: line_st is encoded as 00=SE0, 01=J, 10=K. When the port is idle, powered and suspended, a sample of K whose previous sample was J sets resume_req and chg_flag on the same edge. An SE0-to-K change does not.
- R8: chg_flag stays 1 until a write with wr_chg_clr=1. A write with wr_chg_clr=0 leaves it set. If a wake and a clear fall in the same cycle, the flag stays set.
- R9: While port_pwr=0, resume_req, k_drive and eop_drive read 0 in the same cycle. The sequence is cancelled and does not resume when power returns.
- R10: A start request (a write of 1 or a wake) that arrives during an active sequence neither restarts nor extends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pwr | input | 1 | Port power is on |
| port_susp | input | 1 | Port is in the suspend state |
| line_st | input | 2 | Sampled line state: 00 SE0, 01 J, 10 K |
| wr_en | input | 1 | Status write strobe |
| wr_resume | input | 1 | Write data for the resume request bit |
| wr_chg_clr | input | 1 | Write data for the change flag; 1 clears it |
| resume_req | output | 1 | Resume request bit (read value) |
| k_drive | output | 1 | Enable for driving K on the line |
| eop_drive | output | 1 | Enable for driving the end-of-resume SE0 |
| k_final | output | 1 | Pulse in the last cycle of K drive |
| idle_enter | output | 1 | Pulse in the last cycle before idle |
| chg_flag | output | 1 | Port change detect flag |

## Verification
Two pairs of events can land on the same clock edge. A remote J-to-K wake can coincide with a software write of 1, and a wake can coincide with a write-one-to-clear of the change flag. The bench lines up the J-to-K step with the write strobe on one edge. For the first pair it expects exactly one sequence of the nominal K and SE0 lengths, with the flag set. For the second pair it expects the flag to survive the clear. It also sweeps power, suspend and write data exhaustively with short tick counts, and compares every cycle of each sequence against arithmetic boundaries.

// File: rtl/port_wake_pkg.sv
`timescale 1ns/1ps
package port_wake_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_KDRV = 2'd1,
    PH_EOP  = 2'd2
  } wake_phase_e;

  localparam logic [1:0] LINE_SE0 = 2'b00;
  localparam logic [1:0] LINE_J   = 2'b01;
  localparam logic [1:0] LINE_K   = 2'b10;

  // width needed for a down-counter that loads the larger of two periods
  function automatic int unsigned tick_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m <= 2) ? 1 : $clog2(m);
  endfunction

  function automatic logic is_wake_edge(logic [1:0] prev_st, logic [1:0] cur_st);
    return (prev_st == LINE_J) && (cur_st == LINE_K);
  endfunction

endpackage

// File: rtl/pw_line_edge.sv
`timescale 1ns/1ps
module pw_line_edge
  import port_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_st,
  output logic       jk_seen
);

  logic [1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= LINE_SE0;
    else        prev_q <= line_st;
  end

  assign jk_seen = is_wake_edge(prev_q, line_st);

endmodule

// File: rtl/pw_phase_timer.sv
`timescale 1ns/1ps
module pw_phase_timer
  import port_wake_pkg::*;
#(
  parameter int unsigned RESUME_TICKS = 1200000,
  parameter int unsigned EOP_TICKS    = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abort,
  output wake_phase_e phase,
  output logic        k_last,
  output logic        eop_last
);

  localparam int unsigned CW = tick_width(RESUME_TICKS, EOP_TICKS);
  localparam logic [CW-1:0] K_LOAD   = CW'(RESUME_TICKS - 1);
  localparam logic [CW-1:0] EOP_LOAD = CW'(EOP_TICKS - 1);

  wake_phase_e   phase_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (abort) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_KDRV;
          cnt_q   <= K_LOAD;
        end
        PH_KDRV: if (cnt_zero) begin
          phase_q <= PH_EOP;
          cnt_q   <= EOP_LOAD;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_EOP: if (cnt_zero) begin
          phase_q <= PH_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase    = phase_q;
  assign k_last   = (phase_q == PH_KDRV) && cnt_zero;
  assign eop_last = (phase_q == PH_EOP) && cnt_zero;

endmodule

// File: rtl/pw_change_flag.sv
`timescale 1ns/1ps
module pw_change_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);

  logic flag_q;

  // a set in the same cycle as a clear wins, so no wake is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end

  assign flag = flag_q;

endmodule

// File: rtl/port_wake_ctrl.sv
`timescale 1ns/1ps
module port_wake_ctrl
  import port_wake_pkg::*;
#(
  parameter int unsigned RESUME_TICKS = 1200000,
  parameter int unsigned EOP_TICKS    = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_pwr,
  input  logic       port_susp,
  input  logic [1:0] line_st,
  input  logic       wr_en,
  input  logic       wr_resume,
  input  logic       wr_chg_clr,
  output logic       resume_req,
  output logic       k_drive,
  output logic       eop_drive,
  output logic       k_final,
  output logic       idle_enter,
  output logic       chg_flag
);

  wake_phase_e phase;
  logic        jk_seen;
  logic        k_last;
  logic        eop_last;
  logic        armed;
  logic        wake_evt;
  logic        sw_start;
  logic        chg_clr;

  pw_line_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_st (line_st),
    .jk_seen (jk_seen)
  );

  // a new sequence may begin only from idle on a powered, suspended port
  assign armed    = port_pwr && port_susp && (phase == PH_IDLE);
  assign wake_evt = armed && jk_seen;
  assign sw_start = armed && wr_en && wr_resume;
  assign chg_clr  = wr_en && wr_chg_clr;

  pw_phase_timer #(
    .RESUME_TICKS (RESUME_TICKS),
    .EOP_TICKS    (EOP_TICKS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (wake_evt || sw_start),
    .abort    (!port_pwr),
    .phase    (phase),
    .k_last   (k_last),
    .eop_last (eop_last)
  );

  pw_change_flag u_chg (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (wake_evt),
    .clr_evt (chg_clr),
    .flag    (chg_flag)
  );

  assign resume_req = port_pwr && (phase != PH_IDLE);
  assign k_drive    = port_pwr && (phase == PH_KDRV);
  assign eop_drive  = port_pwr && (phase == PH_EOP);
  assign k_final    = port_pwr && k_last;
  assign idle_enter = port_pwr && eop_last;

endmodule

// File: rtl/port_wake_chk.sv
`timescale 1ns/1ps
module port_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic port_pwr,
  input logic port_susp,
  input logic wr_en,
  input logic wr_resume,
  input logic wr_chg_clr,
  input logic resume_req,
  input logic k_drive,
  input logic eop_drive,
  input logic k_final,
  input logic idle_enter,
  input logic chg_flag,
  input logic wake_evt,
  input logic sw_start
);

  assert_sw_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start |=> (resume_req || !port_pwr));

  assert_kfinal_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    k_final |=> !k_drive);

  assert_kfinal_in_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
    k_final |-> k_drive);

  assert_drive_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({k_drive, eop_drive}));

  assert_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_enter |=> !resume_req);

  assert_keep_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req && !idle_enter) |=> (resume_req || !port_pwr));

  assert_no_start_awake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_susp && !resume_req) |=> !resume_req);

  assert_wake_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> chg_flag);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !(wr_en && wr_chg_clr)) |=> chg_flag);

  assert_unpowered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_pwr |=> !k_drive && !eop_drive || port_pwr);

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_drive && wr_en && wr_resume && !idle_enter) |=> (eop_drive || !port_pwr));

endmodule

bind port_wake_ctrl port_wake_chk u_wake_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_pwr   (port_pwr),
  .port_susp  (port_susp),
  .wr_en      (wr_en),
  .wr_resume  (wr_resume),
  .wr_chg_clr (wr_chg_clr),
  .resume_req (resume_req),
  .k_drive    (k_drive),
  .eop_drive  (eop_drive),
  .k_final    (k_final),
  .idle_enter (idle_enter),
  .chg_flag   (chg_flag),
  .wake_evt   (wake_evt),
  .sw_start   (sw_start)
);

// File: tb/test_port_wake_ctrl.sv
`timescale 1ns/1ps
module test_port_wake_ctrl;

  localparam int RT = 6;
  localparam int ET = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       port_pwr, port_susp;
  logic [1:0] line_st;
  logic       wr_en, wr_resume, wr_chg_clr;
  logic       resume_req, k_drive, eop_drive, k_final, idle_enter, chg_flag;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  port_wake_ctrl #(.RESUME_TICKS(RT), .EOP_TICKS(ET)) i_port_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .port_pwr(port_pwr), .port_susp(port_susp),
    .line_st(line_st), .wr_en(wr_en), .wr_resume(wr_resume), .wr_chg_clr(wr_chg_clr),
    .resume_req(resume_req), .k_drive(k_drive), .eop_drive(eop_drive),
    .k_final(k_final), .idle_enter(idle_enter), .chg_flag(chg_flag)
  );

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_resume = 1'b0; wr_chg_clr = 1'b0;
  endtask

  task automatic start_write();
    wr_en = 1'b1; wr_resume = 1'b1;
    cyc();
    idle_inputs();
  endtask

  task automatic clear_flag();
    wr_en = 1'b1; wr_chg_clr = 1'b1;
    cyc();
    idle_inputs();
  endtask

  // called right after the start edge; mode 1 writes 0, mode 2 writes 1 mid-run
  task automatic check_seq(int mode);
    for (int i = 1; i <= RT + ET; i++) begin
      chk("R3 k_drive", k_drive, i <= RT);
      chk("R4 eop_drive", eop_drive, i > RT);
      chk("R3 k_final", k_final, i == RT);
      chk("R4 idle_enter", idle_enter, i == RT + ET);
      chk(mode == 1 ? "R5 resume_req" : (mode == 2 ? "R10 resume_req" : "R2 resume_req"),
          resume_req, 1'b1);
      if (i == 2 && mode == 1) begin wr_en = 1'b1; wr_resume = 1'b0; end
      if (i == 2 && mode == 2) begin wr_en = 1'b1; wr_resume = 1'b1; end
      cyc();
      idle_inputs();
    end
    chk("R4 self clear", resume_req, 1'b0);
    chk("R4 k_drive off", k_drive, 1'b0);
    chk("R4 eop_drive off", eop_drive, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; port_pwr = 1'b1; port_susp = 1'b1; line_st = 2'b01;
    idle_inputs();
    repeat (3) cyc();
    chk("R1 resume_req", resume_req, 1'b0);
    chk("R1 k_drive", k_drive, 1'b0);
    chk("R1 eop_drive", eop_drive, 1'b0);
    chk("R1 k_final", k_final, 1'b0);
    chk("R1 idle_enter", idle_enter, 1'b0);
    chk("R1 chg_flag", chg_flag, 1'b0);
    rst_n = 1'b1;
    cyc();

    // R2 / R6: power x suspend x write data
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int d = 0; d < 2; d++) begin
          logic exp;
          port_pwr = p[0]; port_susp = s[0];
          cyc();
          wr_en = 1'b1; wr_resume = d[0];
          cyc();
          idle_inputs();
          exp = p[0] & s[0] & d[0];
          chk(exp ? "R2 start" : "R6 ignored", resume_req, exp);
          if (exp) check_seq(0);
        end
      end
    end

    port_pwr = 1'b1; port_susp = 1'b1;
    start_write();
    check_seq(1);
    start_write();
    check_seq(2);

    // R7: remote J-to-K over power x suspend
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 2; s++) begin
        logic exp;
        port_pwr = 1'b1; port_susp = 1'b1;
        clear_flag();
        port_pwr = p[0]; port_susp = s[0];
        line_st = 2'b01;
        cyc(); cyc();
        line_st = 2'b10;
        cyc();
        exp = p[0] & s[0];
        chk("R7 wake resume_req", resume_req, exp);
        chk("R7 wake chg_flag", chg_flag, exp);
        if (exp) check_seq(0);
        line_st = 2'b01;
        cyc();
      end
    end

    // R7: SE0 to K is not a wake
    port_pwr = 1'b1; port_susp = 1'b1;
    clear_flag();
    line_st = 2'b00; cyc();
    line_st = 2'b10; cyc();
    chk("R7 se0-k resume_req", resume_req, 1'b0);
    chk("R7 se0-k chg_flag", chg_flag, 1'b0);
    line_st = 2'b01; cyc();

    // R8: flag persistence and write-one-to-clear
    line_st = 2'b10; cyc();
    chk("R8 flag set", chg_flag, 1'b1);
    check_seq(0);
    chk("R8 flag held after sequence", chg_flag, 1'b1);
    wr_en = 1'b1; wr_chg_clr = 1'b0; cyc(); idle_inputs();
    chk("R8 write 0 keeps flag", chg_flag, 1'b1);
    clear_flag();
    chk("R8 write 1 clears flag", chg_flag, 1'b0);

    // R8: wake and clear on the same edge
    line_st = 2'b01; cyc();
    line_st = 2'b10; wr_en = 1'b1; wr_chg_clr = 1'b1;
    cyc();
    idle_inputs();
    chk("R8 set wins over clear", chg_flag, 1'b1);
    check_seq(0);

    // R10: software write and wake on the same edge give one sequence
    clear_flag();
    line_st = 2'b01; cyc();
    line_st = 2'b10; wr_en = 1'b1; wr_resume = 1'b1;
    cyc();
    idle_inputs();
    chk("R10 joint start flag", chg_flag, 1'b1);
    check_seq(0);

    // R9: power drop mid-sequence
    line_st = 2'b01; cyc();
    start_write();
    cyc(); cyc();
    port_pwr = 1'b0;
    #1;
    chk("R9 resume_req unpowered", resume_req, 1'b0);
    chk("R9 k_drive unpowered", k_drive, 1'b0);
    cyc();
    port_pwr = 1'b1;
    #1;
    chk("R9 cancelled resume_req", resume_req, 1'b0);
    chk("R9 cancelled k_drive", k_drive, 1'b0);
    chk("R9 cancelled eop_drive", eop_drive, 1'b0);
    start_write();
    check_seq(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule